// File: doc/BRIEF.md
# Dual Memory Stack Engine

This block manages two independent 12-bit stack pointers for a small word-oriented processor core. Each stack grows toward lower addresses. Either stack can save the program counter or the accumulator to memory, and either can restore a word from memory into one of those two registers. A stack pointer can also be loaded from the accumulator or cleared. All memory traffic goes through a single-word port with a request/ready handshake.

The core issues a command with `cmd_valid`, an operation code and a stack select bit. The engine latches the operands it needs. It then drives the memory port until `mem_rdy` is returned, and updates the pointer in the order the operation defines. A push stores the word first and moves the pointer down afterwards. A pop moves the pointer up first and then reads. When the operation completes, the engine raises `done` for one cycle. A restored value is presented together with a one-cycle load strobe for the register it targets. A front-panel clear input zeroes both pointers at any time and abandons any operation that is in progress.

Top module: `dual_stack_engine`

## Requirements
- R1: There are two pointers, `sp1` and `sp2`, with identical behaviour. `cmd_sel`=0 selects `sp1` and `cmd_sel`=1 selects `sp2`. An operation never changes the pointer that is not selected.
- R2: `cmd_op` encodes the operation as follows: 1 = save PC, 2 = save AC, 3 = restore to PC, 4 = restore to AC, 5 = load pointer from `ac_in`, 6 = clear pointer. Codes 0 and 7 are ignored: they produce no `done`, no memory strobe and no pointer change.
- R3: A save (code 1 or 2) holds `mem_we` high with `mem_addr` equal to the selected pointer and `mem_wdata` equal to `pc_in` or `ac_in` as captured at acceptance. At the edge where `mem_rdy` is sampled high, the pointer is decremented modulo 4096.
- R4: A restore (code 3 or 4) increments the selected pointer at the acceptance edge. It then holds `mem_re` high with `mem_addr` equal to the new pointer value. At the edge where `mem_rdy` is sampled, `mem_rdata` is captured into `pc_out` (with `pc_load`) for code 3, or into `ac_out` (with `ac_load`) for code 4. The strobe lasts one cycle, and `pc_load` and `ac_load` are never high together.
- R5: Code 5 copies `ac_in` into the selected pointer at the acceptance edge. It makes no memory access, and `done` is high in the following cycle.
- R6: Code 6 sets the selected pointer to zero at the acceptance edge, and `done` is high in the following cycle.
- R7: `panel_clr` sampled high zeroes both pointers and returns the engine to idle with no `done`. It takes priority over any command and any pending memory completion.
- R8: An active-low asynchronous reset `rst_n` zeroes both pointers at once and idles the engine.
- R9: While a memory strobe is high and `mem_rdy` is low, the strobe, `mem_addr` and `mem_wdata` stay unchanged. `mem_we` and `mem_re` are never high together.
- R10: `busy` is high from the acceptance edge of a memory operation until the completing edge. `done` is high for exactly one cycle after the completing edge, and `busy` is low in that cycle. Commands presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| panel_clr | input | 1 | Synchronous clear of both pointers; abandons the current operation |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Operation code |
| cmd_sel | input | 1 | Stack select: 0 = stack 1, 1 = stack 2 |
| pc_in | input | 12 | Current program counter |
| ac_in | input | 12 | Current accumulator |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 12 | Memory write data |
| mem_we | output | 1 | Write request |
| mem_re | output | 1 | Read request |
| mem_rdy | input | 1 | Memory has completed the request |
| mem_rdata | input | 12 | Memory read data |
| busy | output | 1 | Memory operation in progress |
| done | output | 1 | One-cycle completion strobe |
| pc_out | output | 12 | Value restored for the program counter |
| pc_load | output | 1 | Load strobe for `pc_out` |
| ac_out | output | 12 | Value restored for the accumulator |
| ac_load | output | 1 | Load strobe for `ac_out` |
| sp1 | output | 12 | Stack pointer 1 |
| sp2 | output | 12 | Stack pointer 2 |

## Verification
For a save or restore that meets a memory latency of L wait cycles, `done` and any load strobe are due L+1 cycles after the negative edge that follows acceptance. A pointer load or clear gives `done` at that very negative edge. The bench drives commands and `mem_rdy` on falling edges and samples every result on falling edges. It counts those cycles exactly, compares the count with the expected value, and confirms one cycle later that `done` has dropped. The memory strobe, address, data and the pre-incremented pointer are checked at the first falling edge after acceptance, before the memory responds.

// File: rtl/dstk_pkg.sv
package dstk_pkg;
  localparam int DSTK_W = 12;
  localparam int DSTK_N = 2;

  typedef logic [DSTK_W-1:0] word_t;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_PUSH_PC  = 3'd1,
    OP_PUSH_AC  = 3'd2,
    OP_POP_PC   = 3'd3,
    OP_POP_AC   = 3'd4,
    OP_LOAD_SP  = 3'd5,
    OP_CLEAR_SP = 3'd6,
    OP_RSVD     = 3'd7
  } dstk_op_e;

  typedef enum logic [2:0] {
    PA_HOLD,
    PA_ZERO,
    PA_LOAD,
    PA_INC,
    PA_DEC
  } ptr_act_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_WRITE,
    SQ_READ
  } seq_st_e;

  // Pointer arithmetic, wrapping at the word width.
  function automatic word_t ptr_up(input word_t v);
    return v + word_t'(1);
  endfunction

  function automatic word_t ptr_down(input word_t v);
    return v + {DSTK_W{1'b1}};
  endfunction

  function automatic logic op_is_push(input dstk_op_e op);
    return (op == OP_PUSH_PC) || (op == OP_PUSH_AC);
  endfunction

  function automatic logic op_is_pop(input dstk_op_e op);
    return (op == OP_POP_PC) || (op == OP_POP_AC);
  endfunction

  function automatic logic op_is_legal(input dstk_op_e op);
    return (op != OP_NOP) && (op != OP_RSVD);
  endfunction
endpackage

// File: rtl/dstk_ptr.sv
module dstk_ptr
  import dstk_pkg::*;
#(
  parameter int W = DSTK_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ptr_act_e     act,
  input  logic [W-1:0] ac_val,
  output logic [W-1:0] sp
);
  logic [W-1:0] base;
  logic [W-1:0] addend;
  logic [W-1:0] sp_next;

  // One adder serves every pointer update.
  always_comb begin
    base   = sp;
    addend = '0;
    case (act)
      PA_ZERO: begin base = '0;     addend = '0; end
      PA_LOAD: begin base = ac_val; addend = '0; end
      PA_INC:  begin base = sp;     addend = {{(W-1){1'b0}}, 1'b1}; end
      PA_DEC:  begin base = sp;     addend = '1; end
      default: begin base = sp;     addend = '0; end
    endcase
    sp_next = base + addend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp <= '0;
    else        sp <= sp_next;
  end
endmodule

// File: rtl/dstk_seq.sv
module dstk_seq
  import dstk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     panel_clr,
  input  logic     cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic     cmd_sel,
  input  word_t    pc_in,
  input  word_t    ac_in,
  input  word_t    sp1,
  input  word_t    sp2,
  input  logic     mem_rdy,
  input  word_t    mem_rdata,
  output ptr_act_e act1,
  output ptr_act_e act2,
  output word_t    mem_addr,
  output word_t    mem_wdata,
  output logic     mem_we,
  output logic     mem_re,
  output logic     busy,
  output logic     done,
  output word_t    pc_out,
  output logic     pc_load,
  output word_t    ac_out,
  output logic     ac_load,
  output logic     act_sel,
  output logic     ev_accept,
  output logic     ev_wr_fin,
  output logic     ev_rd_fin
);
  seq_st_e  state;
  dstk_op_e op;
  word_t    sp_pick;
  logic     sel_q;
  logic     to_pc_q;
  word_t    addr_q;
  word_t    wdata_q;
  logic     done_q;
  word_t    pc_q;
  logic     pc_ld_q;
  word_t    ac_q;
  logic     ac_ld_q;
  ptr_act_e act_v [DSTK_N];

  assign op      = dstk_op_e'(cmd_op);
  assign sp_pick = cmd_sel ? sp2 : sp1;

  // Named events shared by the state logic and the checker.
  assign ev_accept = cmd_valid && (state == SQ_IDLE) && !panel_clr && op_is_legal(op);
  assign ev_wr_fin = (state == SQ_WRITE) && mem_rdy && !panel_clr;
  assign ev_rd_fin = (state == SQ_READ)  && mem_rdy && !panel_clr;

  always_comb begin
    for (int i = 0; i < DSTK_N; i++) act_v[i] = PA_HOLD;
    if (panel_clr) begin
      for (int i = 0; i < DSTK_N; i++) act_v[i] = PA_ZERO;
    end else if (ev_accept) begin
      if (op_is_pop(op))           act_v[cmd_sel] = PA_INC;
      else if (op == OP_LOAD_SP)   act_v[cmd_sel] = PA_LOAD;
      else if (op == OP_CLEAR_SP)  act_v[cmd_sel] = PA_ZERO;
    end else if (ev_wr_fin) begin
      act_v[sel_q] = PA_DEC;
    end
  end

  assign act1 = act_v[0];
  assign act2 = act_v[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      sel_q   <= 1'b0;
      to_pc_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      pc_q    <= '0;
      pc_ld_q <= 1'b0;
      ac_q    <= '0;
      ac_ld_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      pc_ld_q <= 1'b0;
      ac_ld_q <= 1'b0;
      if (panel_clr) begin
        state <= SQ_IDLE;
      end else begin
        case (state)
          SQ_IDLE: begin
            if (ev_accept) begin
              sel_q <= cmd_sel;
              if (op_is_push(op)) begin
                addr_q  <= sp_pick;
                wdata_q <= (op == OP_PUSH_PC) ? pc_in : ac_in;
                state   <= SQ_WRITE;
              end else if (op_is_pop(op)) begin
                addr_q  <= ptr_up(sp_pick);
                to_pc_q <= (op == OP_POP_PC);
                state   <= SQ_READ;
              end else begin
                done_q <= 1'b1;
              end
            end
          end
          SQ_WRITE: begin
            if (ev_wr_fin) begin
              state  <= SQ_IDLE;
              done_q <= 1'b1;
            end
          end
          SQ_READ: begin
            if (ev_rd_fin) begin
              state  <= SQ_IDLE;
              done_q <= 1'b1;
              if (to_pc_q) begin
                pc_q    <= mem_rdata;
                pc_ld_q <= 1'b1;
              end else begin
                ac_q    <= mem_rdata;
                ac_ld_q <= 1'b1;
              end
            end
          end
          default: state <= SQ_IDLE;
        endcase
      end
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign mem_we    = (state == SQ_WRITE);
  assign mem_re    = (state == SQ_READ);
  assign busy      = (state != SQ_IDLE);
  assign done      = done_q;
  assign pc_out    = pc_q;
  assign pc_load   = pc_ld_q;
  assign ac_out    = ac_q;
  assign ac_load   = ac_ld_q;
  assign act_sel   = sel_q;
endmodule

// File: rtl/dual_stack_engine.sv
module dual_stack_engine
  import dstk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                panel_clr,
  input  logic                cmd_valid,
  input  logic [2:0]          cmd_op,
  input  logic                cmd_sel,
  input  logic [DSTK_W-1:0]   pc_in,
  input  logic [DSTK_W-1:0]   ac_in,
  output logic [DSTK_W-1:0]   mem_addr,
  output logic [DSTK_W-1:0]   mem_wdata,
  output logic                mem_we,
  output logic                mem_re,
  input  logic                mem_rdy,
  input  logic [DSTK_W-1:0]   mem_rdata,
  output logic                busy,
  output logic                done,
  output logic [DSTK_W-1:0]   pc_out,
  output logic                pc_load,
  output logic [DSTK_W-1:0]   ac_out,
  output logic                ac_load,
  output logic [DSTK_W-1:0]   sp1,
  output logic [DSTK_W-1:0]   sp2
);
  ptr_act_e acts [DSTK_N];
  word_t    sp_q [DSTK_N];
  logic     act_sel;
  logic     ev_accept;
  logic     ev_wr_fin;
  logic     ev_rd_fin;

  dstk_seq seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .panel_clr (panel_clr),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_sel   (cmd_sel),
    .pc_in     (pc_in),
    .ac_in     (ac_in),
    .sp1       (sp_q[0]),
    .sp2       (sp_q[1]),
    .mem_rdy   (mem_rdy),
    .mem_rdata (mem_rdata),
    .act1      (acts[0]),
    .act2      (acts[1]),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .busy      (busy),
    .done      (done),
    .pc_out    (pc_out),
    .pc_load   (pc_load),
    .ac_out    (ac_out),
    .ac_load   (ac_load),
    .act_sel   (act_sel),
    .ev_accept (ev_accept),
    .ev_wr_fin (ev_wr_fin),
    .ev_rd_fin (ev_rd_fin)
  );

  for (genvar g = 0; g < DSTK_N; g++) begin : g_ptr
    dstk_ptr #(.W(DSTK_W)) ptr_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .act    (acts[g]),
      .ac_val (ac_in),
      .sp     (sp_q[g])
    );
  end

  assign sp1 = sp_q[0];
  assign sp2 = sp_q[1];
endmodule

// File: rtl/dstk_chk.sv
module dstk_chk
  import dstk_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  panel_clr,
  input logic  mem_we,
  input logic  mem_re,
  input logic  mem_rdy,
  input word_t mem_addr,
  input word_t mem_wdata,
  input logic  busy,
  input logic  done,
  input logic  pc_load,
  input logic  ac_load,
  input word_t sp1,
  input word_t sp2,
  input logic  act_sel,
  input logic  ev_wr_fin,
  input logic  ev_rd_fin
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !(mem_we && mem_re)); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) && !mem_rdy && !panel_clr |=> $stable(mem_addr) && $stable(mem_wdata) && (mem_we || mem_re)); // R9
  AST_PUSH_POSTDEC: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_fin |=> (($past(act_sel) ? sp2 : sp1) == ($past(mem_addr) - 12'd1))); // R3
  AST_POP_PREINC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (mem_addr == (act_sel ? sp2 : sp1))); // R4
  AST_LOAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(pc_load && ac_load)); // R4
  AST_RD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_fin |=> (pc_load || ac_load) && done); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R10
  AST_PANEL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    panel_clr |=> (sp1 == '0) && (sp2 == '0) && !busy && !done); // R7
endmodule

bind dual_stack_engine dstk_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .panel_clr (panel_clr),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .mem_rdy   (mem_rdy),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .busy      (busy),
  .done      (done),
  .pc_load   (pc_load),
  .ac_load   (ac_load),
  .sp1       (sp1),
  .sp2       (sp2),
  .act_sel   (act_sel),
  .ev_wr_fin (ev_wr_fin),
  .ev_rd_fin (ev_rd_fin)
);

// File: tb/dual_stack_engine_tb_top.sv
`timescale 1ns/1ps
module dual_stack_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        panel_clr = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic        cmd_sel = 1'b0;
  logic [11:0] pc_in = '0;
  logic [11:0] ac_in = '0;
  logic [11:0] mem_addr, mem_wdata, mem_rdata, pc_out, ac_out, sp1, sp2;
  logic        mem_we, mem_re, busy, done, pc_load, ac_load;
  logic        mem_rdy = 1'b0;

  logic [11:0] mem [0:4095];
  int          lat = 0;
  int          wcnt = 0;
  int          strobes = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  int          exp_sp [2];
  bit          finished = 0;

  always #2.5 clk = ~clk;

  dual_stack_engine dut_i (
    .clk(clk), .rst_n(rst_n), .panel_clr(panel_clr), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_sel(cmd_sel), .pc_in(pc_in), .ac_in(ac_in),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdy(mem_rdy), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .pc_out(pc_out), .pc_load(pc_load), .ac_out(ac_out), .ac_load(ac_load),
    .sp1(sp1), .sp2(sp2)
  );

  // Memory model: ready after lat waiting cycles, driven on falling edges.
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    if (mem_we && mem_rdy) mem[mem_addr] <= mem_wdata;
    if (mem_we || mem_re) strobes <= strobes + 1;
  end
  always @(negedge clk) begin
    if (mem_we || mem_re) begin
      if (wcnt >= lat) mem_rdy <= 1'b1;
      else wcnt <= wcnt + 1;
    end else begin
      mem_rdy <= 1'b0;
      wcnt <= 0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic int cur_sp(input int s);
    return (s == 0) ? int'(sp1) : int'(sp2);
  endfunction

  // Present one command for one cycle; returns at the falling edge after acceptance.
  task automatic send(input int op, input int sel);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op[2:0]; cmd_sel = sel[0];
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset();
    chk("R8", "sp1 after reset", sp1, 0);
    chk("R8", "sp2 after reset", sp2, 0);
    chk("R8", "busy after reset", busy, 0);
    chk("R8", "done after reset", done, 0);
    chk("R9", "strobes after reset", mem_we | mem_re, 0);
  endtask

  task automatic t_push(input int sel, input bit use_pc, input int val, input int l);
    int cyc; int old; int oth;
    old = exp_sp[sel]; oth = cur_sp(1 - sel); lat = l;
    if (use_pc) begin pc_in = val[11:0]; ac_in = ~val[11:0]; end
    else begin ac_in = val[11:0]; pc_in = ~val[11:0]; end
    send(use_pc ? 1 : 2, sel);
    chk("R3", "mem_we during save", mem_we, 1);
    chk("R3", "save address", mem_addr, old);
    chk("R3", "save data", mem_wdata, val);
    chk("R10", "busy during save", busy, 1);
    pc_in = 12'h000; ac_in = 12'h000;
    wait_done(cyc);
    chk("R10", "save done latency", cyc, l + 1);
    chk("R10", "busy at done", busy, 0);
    chk("R3", "word written", mem[old], val);
    exp_sp[sel] = (old - 1) & 12'hFFF;
    chk("R3", "pointer post-decrement", cur_sp(sel), exp_sp[sel]);
    chk("R1", "other pointer untouched", cur_sp(1 - sel), oth);
    @(negedge clk);
    chk("R10", "done one cycle", done, 0);
  endtask

  task automatic t_pop(input int sel, input bit to_pc, input int l);
    int cyc; int nsp; int val;
    nsp = (exp_sp[sel] + 1) & 12'hFFF; val = mem[nsp]; lat = l;
    send(to_pc ? 3 : 4, sel);
    chk("R4", "pointer pre-increment", cur_sp(sel), nsp);
    chk("R4", "mem_re during restore", mem_re, 1);
    chk("R4", "restore address", mem_addr, nsp);
    wait_done(cyc);
    chk("R10", "restore done latency", cyc, l + 1);
    if (to_pc) begin
      chk("R4", "pc_load", pc_load, 1);
      chk("R4", "pc_out", pc_out, val);
      chk("R4", "ac_load quiet", ac_load, 0);
    end else begin
      chk("R4", "ac_load", ac_load, 1);
      chk("R4", "ac_out", ac_out, val);
      chk("R4", "pc_load quiet", pc_load, 0);
    end
    exp_sp[sel] = nsp;
    @(negedge clk);
    chk("R4", "load strobe one cycle", pc_load | ac_load, 0);
  endtask

  task automatic t_load(input int sel, input int val);
    int cyc; int s0;
    ac_in = val[11:0]; s0 = strobes;
    send(5, sel);
    wait_done(cyc);
    chk("R5", "load done latency", cyc, 0);
    chk("R5", "pointer loaded", cur_sp(sel), val);
    chk("R5", "no memory access", strobes - s0, 0);
    exp_sp[sel] = val;
  endtask

  task automatic t_clear(input int sel);
    int cyc; int oth;
    oth = cur_sp(1 - sel);
    send(6, sel);
    wait_done(cyc);
    chk("R6", "clear done latency", cyc, 0);
    chk("R6", "pointer cleared", cur_sp(sel), 0);
    chk("R1", "other pointer kept", cur_sp(1 - sel), oth);
    exp_sp[sel] = 0;
  endtask

  task automatic t_ignore_busy();
    int cyc; int old;
    old = exp_sp[0]; lat = 4; ac_in = 12'h5A5;
    send(2, 0);
    cmd_valid = 1'b1; cmd_op = 3'd5; cmd_sel = 1'b0; ac_in = 12'hABC;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R9", "address held while waiting", mem_addr, old);
    wait_done(cyc);
    chk("R10", "command during busy ignored", sp1, (old - 1) & 12'hFFF);
    chk("R9", "data held while waiting", mem[old], 12'h5A5);
    exp_sp[0] = (old - 1) & 12'hFFF;
    @(negedge clk);
  endtask

  task automatic t_reserved(input int op);
    int s0; int seen;
    s0 = strobes; seen = 0;
    send(op, 1);
    for (int i = 0; i < 4; i++) begin
      if (done) seen++;
      @(negedge clk);
    end
    chk("R2", "ignored code gives no done", seen, 0);
    chk("R2", "ignored code no memory access", strobes - s0, 0);
    chk("R2", "ignored code sp1", sp1, exp_sp[0]);
    chk("R2", "ignored code sp2", sp2, exp_sp[1]);
  endtask

  task automatic t_panel();
    int seen;
    t_load(0, 12'h055);
    t_load(1, 12'h0AA);
    mem[12'h0AA] = 12'h777; lat = 6; pc_in = 12'h111; seen = 0;
    send(1, 1);
    @(negedge clk);
    panel_clr = 1'b1;
    @(negedge clk);
    panel_clr = 1'b0;
    chk("R7", "sp1 after panel clear", sp1, 0);
    chk("R7", "sp2 after panel clear", sp2, 0);
    chk("R7", "busy after panel clear", busy, 0);
    for (int i = 0; i < 8; i++) begin
      if (done) seen++;
      @(negedge clk);
    end
    chk("R7", "no done after abandon", seen, 0);
    chk("R7", "abandoned save not written", mem[12'h0AA], 12'h777);
    exp_sp[0] = 0; exp_sp[1] = 0;
  endtask

  task automatic t_async_reset();
    t_load(0, 12'h3C3);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R8", "async reset clears sp1", sp1, 0);
    chk("R8", "async reset idles", busy, 0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_sp[0] = 0; exp_sp[1] = 0;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    exp_sp[0] = 0; exp_sp[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_push(0, 1, 12'h321, 0);   // wraps 0 -> FFF
    t_push(0, 0, 12'h456, 2);
    t_pop(0, 0, 1);
    t_pop(0, 1, 0);             // wraps FFF -> 0
    t_load(1, 12'h123);
    t_push(1, 0, 12'h9E1, 3);
    t_pop(1, 1, 2);
    t_clear(1);
    t_ignore_busy();
    t_reserved(0);
    t_reserved(7);
    t_panel();
    t_async_reset();
    summary();
  end

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule